// File: doc/BRIEF.md
# Converter Reset and Calibration Sequencer

This block sits on the host side of a self-calibrating pipelined analog-to-digital converter. It drives the converter's three control lines from a few host requests: an active-high reset line, an active-high calibrate line and an active-low power-enable line. The host can ask it to wake the converter, to recalibrate it after a temperature shift, or to put it to sleep. The sequencer counts cycles of the converter clock. It uses these counts to stretch each control pulse to a safe width, to wait for the references to settle, and to cover the whole calibration run. It also blanks the first words out of the pipeline.

After power-up and after every wake, the sequencer always runs the same steps in order. It pulses reset, then waits for the references to settle, then pulses calibrate, then waits out the calibration run, then waits a few more cycles to let the pipeline flush. Only after all of that does it raise `data_ready`, and the host may trust converted words only while `data_ready` is high. The sequencer latches any sleep or recalibrate request that arrives while it is busy, and serves it on the first cycle it is ready. When both are waiting, sleep wins and the recalibrate request is dropped, because every wake already includes a full calibration.

All four outputs are registered. With the default parameters (for a 2.5 MHz converter clock), a full bring-up takes 2 + 250,000 + 272,800 + 13 clock cycles.

Top module: `conv_cal_seq`

## Requirements
- R1: While `rst` is high, and afterwards until a wake request, all four outputs are 0: `cnv_reset`, `cnv_calib`, `cnv_pwr_n` and `data_ready`. This means the converter is held powered down.
- R2: Suppose `wake_req` is sampled high while the converter is off or asleep. From the next cycle, `cnv_pwr_n` is 1 and `cnv_reset` is 1 for exactly RST_PW cycles.
- R3: After reset falls, `cnv_calib` stays low for exactly SETTLE_CYC cycles and is then high for exactly CAL_PW cycles. Calibrate never rises unless a reset pulse has been given since the last power-up.
- R4: `data_ready` rises exactly CAL_CYC + BLANK_CYC cycles after the first cycle in which `cnv_calib` is high. It stays low for that whole time.
- R5: `data_ready` is never high in a cycle where `cnv_reset` or `cnv_calib` is high.
- R6: A recalibrate request sampled while ready starts a new calibrate pulse in the next cycle, and gives no reset pulse. `data_ready` falls in that same cycle, and it comes back under the timing of R4.
- R7: A sleep request sampled while ready drives `cnv_pwr_n`, `data_ready`, `cnv_reset` and `cnv_calib` all to 0 from the next cycle. They stay there until a wake request.
- R8: A wake from sleep repeats the full reset, settle, calibrate and blank sequence, with the same timing as R2 to R4.
- R9: A sleep or recalibrate request that arrives while a sequence is running is held. When the sequence ends, `data_ready` is high for exactly one cycle, and then the held request is served.
- R10: If sleep and recalibrate are both requested in the same cycle, or are both held, the sequencer goes to sleep and discards the recalibrate request. After the next wake, only one calibration runs.
- R11: Some requests are ignored and do not change the outputs. Sleep and recalibrate requests are ignored while the converter is off or asleep. Wake requests are ignored while a sequence is running or the block is ready.
- R12: Raising `rst` in the middle of a sequence returns the outputs to the R1 state one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Power-up or wake request, one-cycle pulse |
| sleep_req | input | 1 | Sleep request, one-cycle pulse |
| recal_req | input | 1 | Recalibrate request after temperature drift, one-cycle pulse |
| cnv_reset | output | 1 | Converter reset line, active high |
| cnv_calib | output | 1 | Converter calibrate line, active high |
| cnv_pwr_n | output | 1 | Converter power enable; 0 puts it to sleep |
| data_ready | output | 1 | Converted data may be trusted |

## Verification
The two functions that can collide are serving a held request and accepting a new one. Either kind of request can land on the same cycle as the other, or on the cycle where a sequence hands over to ready. The bench drives sleep and recalibrate on the same edge while the block is ready. It then checks that the converter goes to sleep and that a later wake produces only one calibration pulse. It also holds each kind of request during a calibration run. It then judges that the ready window lasts exactly one cycle before the held request takes effect.

// File: rtl/conv_cal_seq_pkg.sv
package conv_cal_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RSTP   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_CALP   = 3'd3,
    ST_CALW   = 3'd4,
    ST_BLANK  = 3'd5,
    ST_READY  = 3'd6,
    ST_SLEEP  = 3'd7
  } seq_state_t;

  localparam int REQ_SLEEP = 0;
  localparam int REQ_RECAL = 1;
  localparam int REQ_N     = 2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_busy(input seq_state_t s);
    return (s == ST_RSTP) || (s == ST_SETTLE) || (s == ST_CALP) ||
           (s == ST_CALW) || (s == ST_BLANK);
  endfunction

endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit - 1'b1);

endmodule

// File: rtl/seq_req_hold.sv
module seq_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (set)   q <= 1'b1;
  end

endmodule

// File: rtl/conv_cal_seq.sv
module conv_cal_seq
  import conv_cal_seq_pkg::*;
#(
  parameter int RST_PW     = 2,
  parameter int SETTLE_CYC = 250000,
  parameter int CAL_PW     = 2,
  parameter int CAL_CYC    = 272800,
  parameter int BLANK_CYC  = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_req,
  input  logic sleep_req,
  input  logic recal_req,
  output logic cnv_reset,
  output logic cnv_calib,
  output logic cnv_pwr_n,
  output logic data_ready
);

  localparam int CALW_CYC = CAL_CYC - CAL_PW;
  localparam int MAX_CYC  = max2(max2(RST_PW, SETTLE_CYC),
                                 max2(max2(CAL_PW, CALW_CYC), BLANK_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;

  seq_state_t state, state_n;
  logic [CNT_W-1:0] limit;
  logic             dwell_done;
  logic [REQ_N-1:0] req_in, req_set, req_clr, req_held, req_eff;
  logic             busy, idle_off;

  assign busy     = is_busy(state);
  assign idle_off = (state == ST_OFF) || (state == ST_SLEEP);

  assign req_in[REQ_SLEEP] = sleep_req;
  assign req_in[REQ_RECAL] = recal_req;
  assign req_eff = req_in | req_held;

  // Held requests: captured while busy, dropped when off/asleep or served.
  always_comb begin
    req_set = req_in & {REQ_N{busy}};
    req_clr = {REQ_N{idle_off}};
    if (state == ST_READY) begin
      req_clr[REQ_SLEEP] = req_eff[REQ_SLEEP];
      req_clr[REQ_RECAL] = req_eff[REQ_SLEEP] | req_eff[REQ_RECAL];
    end
  end

  for (genvar g = 0; g < REQ_N; g++) begin : g_hold
    seq_req_hold u_hold (
      .clk (clk),
      .rst (rst),
      .set (req_set[g]),
      .clr (req_clr[g]),
      .q   (req_held[g])
    );
  end

  always_comb begin
    case (state)
      ST_RSTP:   limit = CNT_W'(RST_PW);
      ST_SETTLE: limit = CNT_W'(SETTLE_CYC);
      ST_CALP:   limit = CNT_W'(CAL_PW);
      ST_CALW:   limit = CNT_W'(CALW_CYC);
      ST_BLANK:  limit = CNT_W'(BLANK_CYC);
      default:   limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_n = state;
    case (state)
      ST_OFF, ST_SLEEP: if (wake_req) state_n = ST_RSTP;
      ST_RSTP:   if (dwell_done) state_n = ST_SETTLE;
      ST_SETTLE: if (dwell_done) state_n = ST_CALP;
      ST_CALP:   if (dwell_done) state_n = ST_CALW;
      ST_CALW:   if (dwell_done) state_n = ST_BLANK;
      ST_BLANK:  if (dwell_done) state_n = ST_READY;
      ST_READY: begin
        if (req_eff[REQ_SLEEP])      state_n = ST_SLEEP;
        else if (req_eff[REQ_RECAL]) state_n = ST_CALP;
      end
      default: state_n = ST_OFF;
    endcase
  end

  seq_dwell_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (state_n != state),
    .limit   (limit),
    .done    (dwell_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      cnv_reset  <= 1'b0;
      cnv_calib  <= 1'b0;
      cnv_pwr_n  <= 1'b0;
      data_ready <= 1'b0;
    end else begin
      state      <= state_n;
      cnv_reset  <= (state_n == ST_RSTP);
      cnv_calib  <= (state_n == ST_CALP);
      cnv_pwr_n  <= (state_n != ST_OFF) && (state_n != ST_SLEEP);
      data_ready <= (state_n == ST_READY);
    end
  end

endmodule

// File: rtl/conv_cal_seq_chk.sv
module conv_cal_seq_chk #(
  parameter int RST_PW    = 2,
  parameter int CAL_PW    = 2,
  parameter int CAL_CYC   = 272800,
  parameter int BLANK_CYC = 13
) (
  input logic clk,
  input logic rst,
  input logic cnv_reset,
  input logic cnv_calib,
  input logic cnv_pwr_n,
  input logic data_ready
);

  localparam int GAP = CAL_CYC + BLANK_CYC - CAL_PW;

  logic rst_seen;
  int   since_cal;

  always_ff @(posedge clk) begin
    if (rst || !cnv_pwr_n) rst_seen <= 1'b0;
    else if (cnv_reset)    rst_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || cnv_calib)     since_cal <= 0;
    else if (since_cal < GAP + 1) since_cal <= since_cal + 1;
  end

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> (!cnv_reset && !cnv_calib)); // R5

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cnv_pwr_n |-> (!cnv_reset && !cnv_calib && !data_ready)); // R7

  AST_CAL_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_calib) |-> rst_seen); // R3

  AST_BLANK_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> (since_cal == GAP)); // R4

  if (RST_PW >= 2) begin : g_rst_min
    AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(cnv_reset) |-> $past(cnv_reset, 2)); // R2
  end

  if (CAL_PW >= 2) begin : g_cal_min
    AST_CAL_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(cnv_calib) |-> $past(cnv_calib, 2)); // R3
  end

endmodule

bind conv_cal_seq conv_cal_seq_chk #(
  .RST_PW(RST_PW), .CAL_PW(CAL_PW), .CAL_CYC(CAL_CYC), .BLANK_CYC(BLANK_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cnv_reset(cnv_reset), .cnv_calib(cnv_calib),
  .cnv_pwr_n(cnv_pwr_n), .data_ready(data_ready)
);

// File: tb/conv_cal_seq_bench.sv
`timescale 1ns/1ps
module conv_cal_seq_bench;

  localparam int P_RST = 2;
  localparam int P_SET = 20;
  localparam int P_CLP = 3;
  localparam int P_CAL = 40;
  localparam int P_BLK = 5;
  localparam int P_WAIT = P_CAL - P_CLP + P_BLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_req = 1'b0, sleep_req = 1'b0, recal_req = 1'b0;
  logic cnv_reset, cnv_calib, cnv_pwr_n, data_ready;
  logic [3:0] obs;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  conv_cal_seq #(
    .RST_PW(P_RST), .SETTLE_CYC(P_SET), .CAL_PW(P_CLP),
    .CAL_CYC(P_CAL), .BLANK_CYC(P_BLK)
  ) u_conv_cal_seq (
    .clk(clk), .rst(rst), .wake_req(wake_req), .sleep_req(sleep_req),
    .recal_req(recal_req), .cnv_reset(cnv_reset), .cnv_calib(cnv_calib),
    .cnv_pwr_n(cnv_pwr_n), .data_ready(data_ready)
  );

  // {reset, calib, pwr_n, ready}
  assign obs = {cnv_reset, cnv_calib, cnv_pwr_n, data_ready};

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Observe n cycles at negedges; report the first mismatch as one check.
  task automatic window(input string req, input string what, input int n,
                        input logic [3:0] exp);
    logic [3:0] seen;
    bit bad;
    seen = exp;
    bad  = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!bad && obs !== exp) begin
        bad  = 1'b1;
        seen = obs;
      end
      @(negedge clk);
    end
    check(req, what, seen, exp);
  endtask

  task automatic pulse(input bit w, input bit s, input bit r);
    wake_req = w; sleep_req = s; recal_req = r;
    @(negedge clk);
    wake_req = 1'b0; sleep_req = 1'b0; recal_req = 1'b0;
  endtask

  task automatic full_bringup(input string req);
    pulse(1'b1, 1'b0, 1'b0);
    window(req, "reset pulse (R2)", P_RST, 4'b1010);
    window(req, "settle (R3/R5)", P_SET, 4'b0010);
    window(req, "calib pulse (R3/R5)", P_CLP, 4'b0110);
    window(req, "cal wait and blank (R4)", P_WAIT, 4'b0010);
    window(req, "ready reached (R4)", 1, 4'b0011);
  endtask

  task automatic calib_only(input string req);
    window(req, "calib pulse", P_CLP, 4'b0110);
    window(req, "cal wait and blank", P_WAIT, 4'b0010);
    window(req, "ready again", 1, 4'b0011);
  endtask

  task automatic t_reset_state();
    window("R1", "after reset", 10, 4'b0000);
    pulse(1'b0, 1'b1, 1'b1);
    window("R11", "sleep/recal while off", 8, 4'b0000);
  endtask

  task automatic t_bringup();
    full_bringup("R2");
    window("R4", "ready holds", 5, 4'b0011);
    pulse(1'b1, 1'b0, 1'b0);
    window("R11", "wake while ready", 5, 4'b0011);
  endtask

  task automatic t_recal();
    pulse(1'b0, 1'b0, 1'b1);
    calib_only("R6");
    window("R6", "ready holds after recal", 3, 4'b0011);
  endtask

  task automatic t_pending_recal();
    pulse(1'b0, 1'b0, 1'b1);
    window("R9", "first calib pulse", P_CLP, 4'b0110);
    window("R9", "wait head", 5, 4'b0010);
    pulse(1'b0, 1'b0, 1'b1);
    window("R9", "wait tail", P_WAIT - 6, 4'b0010);
    window("R9", "one-cycle ready", 1, 4'b0011);
    calib_only("R9");
  endtask

  task automatic t_sleep_wake();
    pulse(1'b0, 1'b1, 1'b0);
    window("R7", "asleep", 3, 4'b0000);
    pulse(1'b0, 1'b0, 1'b1);
    window("R11", "recal while asleep", 6, 4'b0000);
    full_bringup("R8");
  endtask

  task automatic t_priority();
    pulse(1'b0, 1'b1, 1'b1);
    window("R10", "sleep wins", 6, 4'b0000);
    full_bringup("R10");
    window("R10", "no second calibration", P_CAL + 10, 4'b0011);
  endtask

  task automatic t_pending_sleep();
    pulse(1'b0, 1'b0, 1'b1);
    window("R9", "calib before held sleep", P_CLP, 4'b0110);
    pulse(1'b0, 1'b1, 1'b0);
    window("R9", "wait with held sleep", P_WAIT - 1, 4'b0010);
    window("R9", "one-cycle ready before sleep", 1, 4'b0011);
    window("R9", "held sleep served", 5, 4'b0000);
  endtask

  task automatic t_mid_reset();
    pulse(1'b1, 1'b0, 1'b0);
    window("R2", "reset pulse", P_RST, 4'b1010);
    window("R11", "settle head", 3, 4'b0010);
    pulse(1'b1, 1'b0, 1'b0);
    window("R11", "wake while busy ignored", P_SET - 4, 4'b0010);
    window("R11", "calib on time", P_CLP, 4'b0110);
    window("R12", "cal wait head", 4, 4'b0010);
    rst = 1'b1;
    @(negedge clk);
    check("R12", "outputs in reset", obs, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    window("R12", "off after reset", 10, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_bringup();
    t_recal();
    t_pending_recal();
    t_sleep_wake();
    t_priority();
    t_pending_sleep();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule